// File: doc/BRIEF.md
# I2C Register-Access Slave with Auto-Incrementing Pointer

This block is an I2C-compatible slave. It lets a host microcontroller read and write a 16-bit addressed space of byte-wide registers and memory inside the chip. The two bus wires are brought into the system clock domain, and start and stop conditions are decoded there. The slave answers only to the fixed 7-bit device address 0x5D. A write transfer carries a two-byte pointer, low byte first, followed by any number of data bytes. Each data byte goes to a simple synchronous memory port, and the pointer then steps up by one.

A read is set up with a write transfer that carries only the pointer and ends in a stop. A read transfer then streams bytes from consecutive addresses until the master declines one. A repeated start without a stop is also accepted. While the chip signals that its display windows are active, read data is not trustworthy, so the slave returns zero bytes for that time. The SDA output is a pull-low enable for an external open-drain pad.

Top module: `i2c_regport`

## Requirements
- R1: A start condition is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A start from any state, including a repeated start with no stop in between, restarts decoding at the device-address byte.
- R2: The address byte is matched on its upper seven bits against 0x5D, with bit 0 = 1 selecting a read. So 0xBA (write) and 0xBB (read) are acknowledged by pulling SDA low through the ninth SCL high phase. Any other address gets no acknowledge, and the slave drives nothing until the next start.
- R3: In a write transfer, the two bytes after the address form the pointer, the first byte being bits 7:0 and the second bits 15:8. Both are acknowledged.
- R4: Every later byte of a write transfer is acknowledged and produces a single-cycle `mem_we` with `mem_addr` equal to the pointer and `mem_wdata` equal to the byte. The pointer then rises by one and wraps from 0xFFFF to 0x0000.
- R5: A write transfer holding only the two pointer bytes and a stop loads the pointer and causes no `mem_we`.
- R6: In a read transfer, each byte is sent MSB first and is the value returned by `mem_rdata` (one clock after `mem_addr`) for the current pointer. The pointer rises by one for every byte sent.
- R7: After a read byte, an acknowledge from the master makes the slave send the next byte. A not-acknowledge makes it release SDA and stay released until the next start.
- R8: A read byte loaded while `win_en` is high is 0x00. The pointer still advances.
- R9: A stop returns the slave to idle and the pointer keeps its value for the next transfer. The slave changes its SDA drive only while SCL is low, and after reset it drives neither SDA nor `mem_we`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL level from the pad |
| sda_i | input | 1 | SDA level from the pad (wired bus value) |
| sda_oe | output | 1 | Pull SDA low when high |
| win_en | input | 1 | Display windows active; forces read bytes to zero |
| mem_addr | output | 16 | Memory address, always the current pointer |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Single-cycle write strobe |
| mem_rdata | input | 8 | Read data, valid one clock after mem_addr |

## Verification
The hardest state to reach from the ports is what follows a not-acknowledge at the end of a read. The slave must then stay silent even though the master keeps toggling SCL. The stimulus NACKs the last byte of a read and clocks out a further full byte with SDA released, expecting all ones on the bus. It then issues a read without reloading the pointer, to show that the stop kept the pointer. Pointer wrap at 0xFFFF and the zeroing of reads under `win_en` are reached by loading the pointer with address-only writes.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } slv_state_e;

    typedef enum logic [1:0] {
        PH_DEV,
        PH_PTR_LO,
        PH_PTR_HI,
        PH_DATA
    } byte_phase_e;

    // Bus events seen in the system clock domain
    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic scl;
        logic sda;
    } bus_ev_t;

    // Pointer update request from the protocol controller
    typedef struct packed {
        logic              ld_lo;
        logic              ld_hi;
        logic              inc;
        logic [BYTE_W-1:0] data;
    } ptr_cmd_t;

    function automatic logic dev_match(input logic [BYTE_W-1:0] b, input logic [6:0] dev);
        return b[BYTE_W-1:1] == dev;
    endfunction

endpackage

// File: rtl/i2c_rp_sync.sv
module i2c_rp_sync
    import i2c_regport_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic [STAGES-1:0] scl_q, sda_q;
    logic              scl_p, sda_p;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_q <= '1;
                    sda_q <= '1;
                end else begin
                    scl_q <= scl_i;
                    sda_q <= sda_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_q <= '1;
                    sda_q <= '1;
                end else begin
                    scl_q <= {scl_q[STAGES-2:0], scl_i};
                    sda_q <= {sda_q[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_q[STAGES-1];
            sda_p <= sda_q[STAGES-1];
        end
    end

    always_comb begin
        ev.scl      = scl_q[STAGES-1];
        ev.sda      = sda_q[STAGES-1];
        ev.scl_rise = ev.scl & ~scl_p;
        ev.scl_fall = ~ev.scl & scl_p;
        ev.start    = ev.scl & scl_p & sda_p & ~ev.sda;
        ev.stop     = ev.scl & scl_p & ~sda_p & ev.sda;
    end

endmodule

// File: rtl/i2c_rp_ptr.sv
module i2c_rp_ptr
    import i2c_regport_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  ptr_cmd_t         cmd,
    output logic [PTR_W-1:0] ptr
);

    localparam int HI_W = PTR_W - BYTE_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (cmd.ld_lo) begin
            ptr[BYTE_W-1:0] <= cmd.data;
        end else if (cmd.ld_hi) begin
            ptr[PTR_W-1:BYTE_W] <= cmd.data[HI_W-1:0];
        end else if (cmd.inc) begin
            ptr <= ptr + 1'b1;
        end
    end

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (cmd.inc && !cmd.ld_lo && !cmd.ld_hi) |=> ptr == PTR_W'($past(ptr) + 1'b1)); // R6
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!cmd.inc && !cmd.ld_lo && !cmd.ld_hi) |=> $stable(ptr)); // R9

endmodule

// File: rtl/i2c_rp_ctrl.sv
module i2c_rp_ctrl
    import i2c_regport_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h5D
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic              win_en,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              sda_oe,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_wdata,
    output ptr_cmd_t          pcmd
);

    slv_state_e        st;
    byte_phase_e       ph;
    logic [2:0]        bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic              byte_done;
    logic              rd_mode;
    logic              mack;
    logic [BYTE_W-1:0] tx_byte;

    assign tx_byte = win_en ? '0 : mem_rdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            ph        <= PH_DEV;
            bitcnt    <= '0;
            shreg     <= '0;
            byte_done <= 1'b0;
            rd_mode   <= 1'b0;
            mack      <= 1'b0;
            sda_oe    <= 1'b0;
            mem_we    <= 1'b0;
            mem_wdata <= '0;
            pcmd      <= '0;
        end else begin
            pcmd.ld_lo <= 1'b0;
            pcmd.ld_hi <= 1'b0;
            pcmd.inc   <= mem_we;
            mem_we     <= 1'b0;
            if (ev.start) begin
                st        <= ST_RX;
                ph        <= PH_DEV;
                bitcnt    <= '0;
                byte_done <= 1'b0;
                sda_oe    <= 1'b0;
            end else if (ev.stop) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    ST_RX: begin
                        if (ev.scl_rise && !byte_done) begin
                            shreg  <= {shreg[BYTE_W-2:0], ev.sda};
                            bitcnt <= bitcnt + 1'b1;
                            if (bitcnt == 3'd7) byte_done <= 1'b1;
                        end else if (ev.scl_fall && byte_done) begin
                            byte_done <= 1'b0;
                            bitcnt    <= '0;
                            sda_oe    <= 1'b1;
                            st        <= ST_RX_ACK;
                            case (ph)
                                PH_DEV: begin
                                    if (dev_match(shreg, DEV_ADDR)) begin
                                        rd_mode <= shreg[0];
                                        ph      <= PH_PTR_LO;
                                    end else begin
                                        sda_oe <= 1'b0;
                                        st     <= ST_IGNORE;
                                    end
                                end
                                PH_PTR_LO: begin
                                    pcmd.ld_lo <= 1'b1;
                                    pcmd.data  <= shreg;
                                    ph         <= PH_PTR_HI;
                                end
                                PH_PTR_HI: begin
                                    pcmd.ld_hi <= 1'b1;
                                    pcmd.data  <= shreg;
                                    ph         <= PH_DATA;
                                end
                                default: begin
                                    mem_we    <= 1'b1;
                                    mem_wdata <= shreg;
                                end
                            endcase
                        end
                    end
                    ST_RX_ACK: begin
                        if (ev.scl_fall) begin
                            if (rd_mode) begin
                                shreg    <= tx_byte;
                                sda_oe   <= ~tx_byte[BYTE_W-1];
                                pcmd.inc <= 1'b1;
                                bitcnt   <= '0;
                                st       <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                st     <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev.scl_fall) begin
                            if (bitcnt == 3'd7) begin
                                sda_oe <= 1'b0;
                                st     <= ST_TX_ACK;
                            end else begin
                                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~shreg[BYTE_W-2];
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (ev.scl_rise) begin
                            mack <= ~ev.sda;
                        end else if (ev.scl_fall) begin
                            if (mack) begin
                                shreg    <= tx_byte;
                                sda_oe   <= ~tx_byte[BYTE_W-1];
                                pcmd.inc <= 1'b1;
                                bitcnt   <= '0;
                                st       <= ST_TX;
                            end else begin
                                st <= ST_IGNORE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we); // R4
    AST_WE_WRITE_DATA: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (ph == PH_DATA && !rd_mode)); // R4
    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !ev.scl); // R9
    AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (rst)
        st == ST_IGNORE |-> !sda_oe); // R7
    AST_TX_ENTRY_STEP: assert property (@(posedge clk) disable iff (rst)
        (st == ST_TX && $past(st) != ST_TX) |-> pcmd.inc); // R6
    AST_RESTART_DEV: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (st == ST_RX && ph == PH_DEV && !sda_oe)); // R1

endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
    import i2c_regport_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h5D,
    parameter int         PTR_W       = 16,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    input  logic             win_en,
    output logic [PTR_W-1:0] mem_addr,
    output logic [7:0]       mem_wdata,
    output logic             mem_we,
    input  logic [7:0]       mem_rdata
);

    bus_ev_t  ev;
    ptr_cmd_t pcmd;

    i2c_rp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_rp_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .win_en    (win_en),
        .mem_rdata (mem_rdata),
        .sda_oe    (sda_oe),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .pcmd      (pcmd)
    );

    i2c_rp_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk (clk),
        .rst (rst),
        .cmd (pcmd),
        .ptr (mem_addr)
    );

endmodule

// File: tb/i2c_regport_tb_top.sv
`timescale 1ns/1ps
module i2c_regport_tb_top;

    localparam int Q = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        m_scl;
    logic        m_sda_low;
    logic        win_en;
    logic        sda_oe;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic [7:0]  mem_rdata;
    logic        sda_bus;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    assign sda_bus = !(m_sda_low || sda_oe);

    i2c_regport dut_i (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (m_scl),
        .sda_i     (sda_bus),
        .sda_oe    (sda_oe),
        .win_en    (win_en),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata)
    );

    // Environment memory (synchronous read)
    logic [7:0] bmem [int];
    always @(posedge clk) begin
        if (mem_we) bmem[mem_addr] = mem_wdata;
        mem_rdata <= bmem.exists(int'(mem_addr)) ? bmem[int'(mem_addr)] : 8'h00;
    end

    // Reference model state
    logic [7:0]  ref_mem [int];
    logic [15:0] mptr;
    logic [23:0] wq [$];
    logic [7:0]  wbuf [0:3];
    logic        prev_oe = 1'b0;
    int          oe_bad  = 0;

    function automatic logic [7:0] ref_get(input logic [15:0] a);
        return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-clock comparison against the expected write stream
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_we) begin
                if (wq.size() == 0) begin
                    chk(1'b0, "R4/R5 unexpected write", int'({mem_addr, mem_wdata}), 0);
                end else begin
                    logic [23:0] e;
                    e = wq.pop_front();
                    chk({mem_addr, mem_wdata} == e, "R4 write addr/data", int'({mem_addr, mem_wdata}), int'(e));
                end
            end
            if (sda_oe && !prev_oe && m_scl) oe_bad++;
            prev_oe <= sda_oe;
        end
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; wt(Q);
        m_scl = 1'b1;     wt(Q);
        m_sda_low = 1'b1; wt(Q);
        m_scl = 1'b0;     wt(Q);
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; wt(Q);
        m_scl = 1'b1;     wt(Q);
        m_sda_low = 1'b0; wt(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda_low = ~b[i]; wt(Q);
            m_scl = 1'b1;      wt(Q);
            m_scl = 1'b0;      wt(Q);
        end
        m_sda_low = 1'b0; wt(Q);
        m_scl = 1'b1;     wt(Q/2);
        ack = !sda_bus;   wt(Q/2);
        m_scl = 1'b0;     wt(Q);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        m_sda_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wt(Q);
            m_scl = 1'b1; wt(Q/2);
            b[i] = sda_bus; wt(Q/2);
            m_scl = 1'b0;
        end
        wt(Q/2);
        m_sda_low = give_ack; wt(Q/2);
        m_scl = 1'b1; wt(Q);
        m_scl = 1'b0; wt(Q);
        m_sda_low = 1'b0;
    endtask

    task automatic write_xfer(input logic [15:0] p, input int n, input bit do_stop);
        bit ack;
        bus_start();
        send_byte(8'hBA, ack);  chk(ack, "R2 write address ack", ack, 1);
        send_byte(p[7:0], ack); chk(ack, "R3 pointer low ack", ack, 1);
        send_byte(p[15:8], ack); chk(ack, "R3 pointer high ack", ack, 1);
        mptr = p;
        for (int i = 0; i < n; i++) begin
            wq.push_back({mptr, wbuf[i]});
            ref_mem[int'(mptr)] = wbuf[i];
            send_byte(wbuf[i], ack); chk(ack, "R4 data ack", ack, 1);
            mptr = mptr + 16'd1;
        end
        if (do_stop) bus_stop();
        wt(4);
        chk(wq.size() == 0, "R4/R5 expected writes done", wq.size(), 0);
    endtask

    task automatic read_xfer(input int n, input bit blank, input bit tail, input bit restart);
        bit         ack;
        logic [7:0] b;
        logic [7:0] e;
        bus_start();
        send_byte(8'hBB, ack); chk(ack, restart ? "R1 repeated start read ack" : "R2 read address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            e = blank ? 8'h00 : ref_get(mptr);
            recv_byte(i < n - 1, b);
            chk(b == e, blank ? "R8 blanked read" : "R6 read data", b, e);
            mptr = mptr + 16'd1;
        end
        if (tail) begin
            recv_byte(1'b0, b);
            chk(b == 8'hFF, "R7 released after NACK", b, 8'hFF);
        end
        bus_stop();
        wt(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        bit ack;
        rst = 1'b1; m_scl = 1'b1; m_sda_low = 1'b0; win_en = 1'b0; mptr = '0;
        bmem[16'h0137]    = 8'h66; ref_mem[16'h0137] = 8'h66;
        bmem[16'h0138]    = 8'h77; ref_mem[16'h0138] = 8'h77;
        bmem[16'h0200]    = 8'h3C; ref_mem[16'h0200] = 8'h3C;
        wt(5);
        rst = 1'b0;
        wt(3);
        chk(!sda_oe && !mem_we, "R9 reset state", {sda_oe, mem_we}, 0);

        // R4: multi-byte write
        wbuf[0] = 8'hA5; wbuf[1] = 8'h5A; wbuf[2] = 8'hC3;
        write_xfer(16'h0134, 3, 1'b1);

        // R2: wrong address gets no ack and the following bytes are ignored
        bus_start();
        send_byte(8'hB0, ack); chk(!ack, "R2 foreign address no ack", ack, 0);
        send_byte(8'h12, ack); chk(!ack, "R2 ignored byte no ack", ack, 0);
        send_byte(8'h34, ack); chk(!ack, "R2 ignored byte no ack", ack, 0);
        bus_stop();
        wt(4);

        // R5: address-only write, then R6/R7 read with NACK and tail
        write_xfer(16'h0135, 0, 1'b1);
        read_xfer(3, 1'b0, 1'b1, 1'b0);

        // R9: pointer kept across stop
        read_xfer(1, 1'b0, 1'b0, 1'b0);
        chk(mptr == 16'h0139, "R9 model pointer", mptr, 16'h0139);

        // R8: blanked reads while windows active
        write_xfer(16'h0134, 0, 1'b1);
        win_en = 1'b1;
        read_xfer(2, 1'b1, 1'b0, 1'b0);
        win_en = 1'b0;
        read_xfer(1, 1'b0, 1'b0, 1'b0);

        // R1: repeated start between pointer load and read
        write_xfer(16'h0200, 0, 1'b0);
        read_xfer(1, 1'b0, 1'b0, 1'b1);

        // R4/R6: pointer wrap
        wbuf[0] = 8'h81; wbuf[1] = 8'h82;
        write_xfer(16'hFFFF, 2, 1'b1);
        write_xfer(16'hFFFF, 0, 1'b1);
        read_xfer(2, 1'b0, 1'b0, 1'b0);

        chk(oe_bad == 0, "R9 SDA drive changes only with SCL low", oe_bad, 0);
        chk(wq.size() == 0, "R5 no stray writes pending", wq.size(), 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule